// File: doc/BRIEF.md
# Relocatable Configuration Register Window

This block is a memory-mapped slave that serves a small set of system configuration registers. All of them sit in one 1 MiB window of a 32-bit address space. The window's base address is stored in a register that lies inside the same window. When software writes that register, the whole decode region moves. From the next cycle on, accesses hit only at the new location, and the old location falls silent.

Requests arrive on a single-cycle bus made of valid, write, address and write data. Every request completes in the cycle it is presented, so the block never applies back-pressure and has no ready signal. The response is combinational:

- a hit flag, raised for any valid request that falls inside the current window;
- read data, non-zero only for a valid read that hits.

Most registers return constants, or values derived from parameters: memory bounds, a memory-config marker, an error-detect register that always reads zero, and a clock-status word. The error-disable register keeps a masked copy of what is written to it.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the window base equals parameter BASE_RST (default 0xFF70_0000), and the error-disable register holds zero.
- R2: A request hits only when req_valid is high and req_addr[31:20] equals the current base bits 31:20. On a miss, rsp_hit is low and rsp_rdata is zero.
- R3: A read at offset 0x00000 returns the base shifted right by 12, so base bits 31:20 appear in read bits 19:8 and all other bits are zero.
- R4: A write at offset 0x00000 keeps only wdata bits 19:8, and the new base is wdata[19:8] shifted left by 20. From the next cycle on, the old window no longer responds and the new one does.
- R5: A write takes effect at the clock edge that ends its cycle. Its own hit is judged against the old base, and a read returns the stored value as it stands before that edge.
- R6: A read at offset 0x02000 returns (MEM_SIZE - 1) >> 24. With the default MEM_SIZE of 0x1000_0000 this is 0x0000_000F.
- R7: A read at offset 0x02080 returns 0x8000_0000.
- R8: A read at offset 0x02E40 returns zero, and writes there change nothing.
- R9: A write at offset 0x02E44 stores wdata & 0xD (bits 3, 2 and 0), and a read there returns the stored value.
- R10: A read at offset 0xE0000 returns parameter CLK_STATUS (default 0x0000_4A21), and writes there change nothing.
- R11: A read at an unmapped offset inside the window hits and returns zero. Writes to unmapped or read-only offsets leave the base and error-disable registers unchanged.
- R12: rsp_rdata is zero for any write request and whenever req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_hit | output | 1 | Request falls inside the current window |
| rsp_rdata | output | 32 | Read data (zero unless a hitting read) |

## Verification
Hit and read data are combinational, so they are due in the same cycle as the request. The bench drives each request on a falling edge and samples one nanosecond later, before the next rising edge. A write's effect on stored state is due only after the next rising edge. Stored state is therefore always checked by a separate read in the following cycle, including the relocation case, where the base-write itself must still hit at the old address.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam logic [19:0] OFS_BASE = 20'h00000;
  localparam logic [19:0] OFS_BNDS = 20'h02000;
  localparam logic [19:0] OFS_MCFG = 20'h02080;
  localparam logic [19:0] OFS_EDET = 20'h02E40;
  localparam logic [19:0] OFS_EDIS = 20'h02E44;
  localparam logic [19:0] OFS_CLKS = 20'hE0000;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_BASE, SEL_BNDS, SEL_MCFG, SEL_EDET, SEL_EDIS, SEL_CLKS
  } reg_sel_e;
endpackage

// File: rtl/cfgwin_match.sv
module cfgwin_match #(
  parameter int ADDR_W = 32,
  parameter int WIN_BITS = 20,
  localparam int HI_W = ADDR_W - WIN_BITS
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [HI_W-1:0]   base_hi,
  output logic              hit,
  output logic [WIN_BITS-1:0] offset
);
  assign hit    = req_valid && (req_addr[ADDR_W-1:WIN_BITS] == base_hi);
  assign offset = req_addr[WIN_BITS-1:0];
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
(
  input  logic [19:0] offset,
  output reg_sel_e    sel
);
  always_comb begin
    unique case (offset)
      OFS_BASE: sel = SEL_BASE;
      OFS_BNDS: sel = SEL_BNDS;
      OFS_MCFG: sel = SEL_MCFG;
      OFS_EDET: sel = SEL_EDET;
      OFS_EDIS: sel = SEL_EDIS;
      OFS_CLKS: sel = SEL_CLKS;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_BITS = 20,
  parameter int SHIFT = 12,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'hFF70_0000,
  parameter int EDIS_W = 4,
  parameter logic [EDIS_W-1:0] EDIS_MASK = 4'hD,
  localparam int HI_W = ADDR_W - WIN_BITS,
  localparam int FLD_LO = WIN_BITS - SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [HI_W-1:0]   base_hi,
  output logic [EDIS_W-1:0] edis
);
  localparam logic [HI_W-1:0] BASE_HI_RST = BASE_RST[ADDR_W-1:WIN_BITS];

  logic base_we, edis_we;
  assign base_we = wr_en && (sel == SEL_BASE);
  assign edis_we = wr_en && (sel == SEL_EDIS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= BASE_HI_RST;
      edis    <= '0;
    end else begin
      if (base_we) base_hi <= wdata[FLD_LO+HI_W-1:FLD_LO];
      if (edis_we) edis    <= wdata[EDIS_W-1:0] & EDIS_MASK;
    end
  end

  assert_base_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (base_hi == BASE_HI_RST && edis == '0));
  assert_base_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_BASE) |=> base_hi == $past(wdata[FLD_LO+HI_W-1:FLD_LO]));
  assert_edis_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_EDIS) |=> edis == ($past(wdata[EDIS_W-1:0]) & EDIS_MASK));
  assert_base_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_BASE) |=> $stable(base_hi));
  assert_edis_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_EDIS) |=> $stable(edis));
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] BASE_RST   = 32'hFF70_0000,
  parameter logic [31:0] MEM_SIZE   = 32'h1000_0000,
  parameter logic [31:0] CLK_STATUS = 32'h0000_4A21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_hit,
  output logic [31:0] rsp_rdata
);
  localparam int ADDR_W = 32;
  localparam int WIN_BITS = 20;
  localparam int SHIFT = 12;
  localparam int HI_W = ADDR_W - WIN_BITS;
  localparam int EDIS_W = 4;
  localparam logic [31:0] BNDS_VAL = (MEM_SIZE - 32'd1) >> 24;
  localparam logic [31:0] MCFG_VAL = 32'h8000_0000;

  logic [HI_W-1:0]     base_hi;
  logic [EDIS_W-1:0]   edis;
  logic [WIN_BITS-1:0] offset;
  logic                hit;
  reg_sel_e            sel;

  cfgwin_match #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_match (
    .req_valid(req_valid), .req_addr(req_addr), .base_hi(base_hi),
    .hit(hit), .offset(offset));

  cfgwin_decode u_dec (.offset(offset), .sel(sel));

  cfgwin_regs #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SHIFT(SHIFT),
    .BASE_RST(BASE_RST), .EDIS_W(EDIS_W), .EDIS_MASK(4'hD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(hit && req_write), .sel(sel),
    .wdata(req_wdata), .base_hi(base_hi), .edis(edis));

  logic rd_en;
  assign rd_en   = hit && !req_write;
  assign rsp_hit = hit;

  always_comb begin
    rsp_rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_BASE: rsp_rdata = {{SHIFT{1'b0}}, base_hi, {(WIN_BITS-SHIFT){1'b0}}};
        SEL_BNDS: rsp_rdata = BNDS_VAL;
        SEL_MCFG: rsp_rdata = MCFG_VAL;
        SEL_EDIS: rsp_rdata = {{(ADDR_W-EDIS_W){1'b0}}, edis};
        SEL_CLKS: rsp_rdata = CLK_STATUS;
        default:  rsp_rdata = '0;
      endcase
    end
  end

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_rdata == '0);
  assert_write_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> rsp_rdata == '0);
  assert_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && req_write && offset == OFS_BASE
     && req_wdata[31:20] != 12'(req_wdata[19:8]))
    |=> !(req_valid && req_addr == $past(req_addr)) || !rsp_hit
        || req_addr[31:20] == $past(req_wdata[19:8]));
endmodule

// File: tb/sim_cfgwin_top.sv
module sim_cfgwin_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_hit;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cfgwin_top u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata));

  // {tag, valid, write, addr, wdata, exp_hit, exp_rdata}
  localparam int NV = 30;
  localparam logic [122:0] TBL [0:NV-1] = '{
    {"R3 ", 1'b1, 1'b0, 32'hFF70_0000, 32'h0,          1'b1, 32'h000F_F700},
    {"R6 ", 1'b1, 1'b0, 32'hFF70_2000, 32'h0,          1'b1, 32'h0000_000F},
    {"R7 ", 1'b1, 1'b0, 32'hFF70_2080, 32'h0,          1'b1, 32'h8000_0000},
    {"R8 ", 1'b1, 1'b0, 32'hFF70_2E40, 32'h0,          1'b1, 32'h0},
    {"R12", 1'b1, 1'b1, 32'hFF70_2E40, 32'hFFFF_FFFF,  1'b1, 32'h0},
    {"R8 ", 1'b1, 1'b0, 32'hFF70_2E40, 32'h0,          1'b1, 32'h0},
    {"R9 ", 1'b1, 1'b0, 32'hFF70_2E44, 32'h0,          1'b1, 32'h0},
    {"R12", 1'b1, 1'b1, 32'hFF70_2E44, 32'hFFFF_FFFF,  1'b1, 32'h0},
    {"R9 ", 1'b1, 1'b0, 32'hFF70_2E44, 32'h0,          1'b1, 32'h0000_000D},
    {"R9 ", 1'b1, 1'b1, 32'hFF70_2E44, 32'h0000_0002,  1'b1, 32'h0},
    {"R9 ", 1'b1, 1'b0, 32'hFF70_2E44, 32'h0,          1'b1, 32'h0},
    {"R9 ", 1'b1, 1'b1, 32'hFF70_2E44, 32'h0000_0005,  1'b1, 32'h0},
    {"R9 ", 1'b1, 1'b0, 32'hFF70_2E44, 32'h0,          1'b1, 32'h0000_0005},
    {"R10", 1'b1, 1'b0, 32'hFF7E_0000, 32'h0,          1'b1, 32'h0000_4A21},
    {"R10", 1'b1, 1'b1, 32'hFF7E_0000, 32'h0,          1'b1, 32'h0},
    {"R10", 1'b1, 1'b0, 32'hFF7E_0000, 32'h0,          1'b1, 32'h0000_4A21},
    {"R11", 1'b1, 1'b0, 32'hFF70_0004, 32'h0,          1'b1, 32'h0},
    {"R11", 1'b1, 1'b1, 32'hFF70_0004, 32'hFFFF_FFFF,  1'b1, 32'h0},
    {"R11", 1'b1, 1'b1, 32'hFF70_2000, 32'hFFFF_FFFF,  1'b1, 32'h0},
    {"R11", 1'b1, 1'b0, 32'hFF70_0000, 32'h0,          1'b1, 32'h000F_F700},
    {"R11", 1'b1, 1'b0, 32'hFF70_2E44, 32'h0,          1'b1, 32'h0000_0005},
    {"R2 ", 1'b1, 1'b0, 32'hFF80_0000, 32'h0,          1'b0, 32'h0},
    {"R2 ", 1'b1, 1'b0, 32'hFF6F_FFFC, 32'h0,          1'b0, 32'h0},
    {"R12", 1'b0, 1'b0, 32'hFF70_0000, 32'h0,          1'b0, 32'h0},
    {"R5 ", 1'b1, 1'b1, 32'hFF70_0000, 32'hFFF1_2345,  1'b1, 32'h0},
    {"R4 ", 1'b1, 1'b0, 32'hFF70_0000, 32'h0,          1'b0, 32'h0},
    {"R4 ", 1'b1, 1'b0, 32'h1230_0000, 32'h0,          1'b1, 32'h0001_2300},
    {"R4 ", 1'b1, 1'b0, 32'h1230_2E44, 32'h0,          1'b1, 32'h0000_0005},
    {"R4 ", 1'b1, 1'b0, 32'h123F_FFFC, 32'h0,          1'b1, 32'h0},
    {"R2 ", 1'b1, 1'b0, 32'h1240_0000, 32'h0,          1'b0, 32'h0}
  };

  task automatic check(input string tag, input logic ah, input logic [31:0] ad,
                       input logic eh, input logic [31:0] ed);
    n_chk++;
    if (ah !== eh || ad !== ed) begin
      n_fail++;
      $display("FAIL %s: hit=%b rdata=%h expected hit=%b rdata=%h", tag, ah, ad, eh, ed);
    end
  endtask

  task automatic access(input logic v, input logic w, input logic [31:0] a,
                        input logic [31:0] d, input string tag,
                        input logic eh, input logic [31:0] ed);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    #1 check(tag, rsp_hit, rsp_rdata, eh, ed);
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset value visible while reset is held (reads are combinational)
    req_valid = 1'b1; req_addr = 32'hFF70_0000;
    #1 check("R1", rsp_hit, rsp_rdata, 1'b1, 32'h000F_F700);
    @(negedge clk); rst_n = 1'b1; req_valid = 1'b0;
    for (int i = 0; i < NV; i++) begin
      access(TBL[i][98], TBL[i][97], TBL[i][96:65], TBL[i][64:33],
             string'(TBL[i][122:99]), TBL[i][32], TBL[i][31:0]);
    end
    // R4: only wdata[19:8] is kept, so these data move the base to zero
    access(1'b1, 1'b1, 32'h1230_0000, 32'hFFF0_00FF, "R4", 1'b1, 32'h0);
    access(1'b1, 1'b0, 32'h0000_0000, 32'h0, "R4", 1'b1, 32'h0);
    access(1'b1, 1'b0, 32'h1230_0000, 32'h0, "R4", 1'b0, 32'h0);
    // R1: a fresh reset restores the default window and clears error-disable
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b1, 1'b0, 32'hFF70_0000, 32'h0, "R1", 1'b1, 32'h000F_F700);
    access(1'b1, 1'b0, 32'hFF70_2E44, 32'h0, "R1", 1'b1, 32'h0);
    access(1'b1, 1'b0, 32'h0000_0000, 32'h0, "R2", 1'b0, 32'h0);
    @(negedge clk); req_valid = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule